// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block guesses the direction of conditional branches by combining two kinds of context. Low-order bits of the branch address pick a row of a small table. A short shift register holds the outcomes of the most recently resolved branches, across all addresses, and picks one of the saturating two-bit counters inside that row. The upper bit of the chosen counter is the taken/not-taken guess, and the whole counter is also exposed as a confidence value.

The lookup side is purely combinational. A fetch stage presents an address and gets a prediction back in the same cycle. When a branch resolves, the execute stage presents its address and its real outcome. On the next clock edge the counter picked by the current history is stepped, and the history then shifts the outcome in. Each counter walks through four named states: strong not-taken `C_SNT` (00), weak not-taken `C_WNT` (01), weak taken `C_WT` (10) and strong taken `C_ST` (11). The transitions are as follows:

- A taken outcome moves `C_SNT` to `C_WNT`, and moves `C_WNT`, `C_WT` and `C_ST` to `C_ST`.
- A not-taken outcome moves `C_ST` to `C_WT`, and moves `C_WT`, `C_WNT` and `C_SNT` to `C_SNT`.

With a history length of zero the block becomes a plain table of two-bit counters indexed by address.

Top module: `corr_predictor`

## Requirements
- R1: After reset the history register is 0 and every counter reads 00, so every lookup predicts not-taken with `lk_ctr` = 00.
- R2: The row is chosen by address bits `[PC_LSB +: IDX_W]`. Addresses that differ only outside that field share a row.
- R3: Within a row, the counter whose column number equals the current history value (0 for history 00 up to 3 for history 11) is the one returned on `lk_ctr`.
- R4: `lk_taken` is 1 exactly when the selected counter is 10 or 11.
- R5: A resolve step changes only the one counter it selects. Every other counter keeps its value.
- R6: On every resolve the history shifts one place toward the MSB and the outcome enters the LSB, with 1 meaning taken. For example, 01 followed by taken gives 11, and 11 followed by not-taken gives 10.
- R7: On a taken outcome the selected counter goes 00 to 01, and goes from 01, 10 or 11 to 11.
- R8: On a not-taken outcome the selected counter goes 11 to 10, and goes from 10, 01 or 00 to 00.
- R9: The counter stepped by a resolve is the one selected by the history value held before that same resolve shifts it.
- R10: While `res_valid` is 0, neither the history nor any counter changes, whatever the other resolve inputs carry.
- R11: A lookup made in the same cycle as a resolve returns the state from before that resolve. The update becomes visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_ctr | output | 2 | Value of the selected counter |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Real outcome, 1 = taken |

## Verification
The bench builds the block with a history length of 2, 8 rows and address bits [4:2] as the row field. With only 8 rows, random 32-bit addresses alias constantly, so every one of the 32 counters is revisited in every history context and driven through all eight transitions many times. The four-entry history is short enough that random outcomes reach all of its values quickly. Directed sequences cover the following:

- lookups made in the same cycle as a resolve to the same row;
- lookups to addresses that alias into one row;
- idle cycles with noisy resolve inputs, followed by a full scan of the rows.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        C_SNT = 2'b00,
        C_WNT = 2'b01,
        C_WT  = 2'b10,
        C_ST  = 2'b11
    } ctr_e;

    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        unique case (cur)
            C_SNT: nxt = taken ? C_WNT : C_SNT;
            C_WNT: nxt = taken ? C_ST  : C_SNT;
            C_WT:  nxt = taken ? C_ST  : C_SNT;
            C_ST:  nxt = taken ? C_ST  : C_WT;
            default: nxt = C_SNT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
    parameter int HIST_W = 2,
    localparam int GW = (HIST_W > 0) ? HIST_W : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          outcome,
    output logic [GW-1:0] hist
);
    generate
        if (HIST_W > 0) begin : g_hist
            logic [GW-1:0] hist_q;
            logic [GW-1:0] hist_d;

            always_comb begin
                hist_d = hist_q;
                if (shift_en) begin
                    hist_d = GW'({hist_q, outcome});
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else begin
                    hist_q <= hist_d;
                end
            end

            assign hist = hist_q;
        end else begin : g_nohist
            logic unused_in;
            assign unused_in = shift_en ^ outcome ^ clk ^ rst_n;
            assign hist = '0;
        end
    endgenerate
endmodule

// File: rtl/bp_ctr_cell.sv
module bp_ctr_cell
    import bp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       taken,
    output logic [1:0] value
);
    ctr_e state_q;
    ctr_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_SNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            state_d = ctr_step(state_q, taken);
        end
    end

    assign value = state_q;
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
    parameter int CELLS  = 16,
    parameter int CELL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CELL_W-1:0]    wr_cell,
    input  logic                 wr_taken,
    output logic [CELLS*2-1:0]   tbl_flat
);
    generate
        for (genvar i = 0; i < CELLS; i++) begin : g_cell
            logic hit;
            assign hit = we && (wr_cell == CELL_W'(i));
            bp_ctr_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .step  (hit),
                .taken (wr_taken),
                .value (tbl_flat[i*2 +: 2])
            );
        end
    endgenerate
endmodule

// File: rtl/corr_predictor.sv
module corr_predictor #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 3,
    parameter int HIST_W = 2,
    localparam int GW     = (HIST_W > 0) ? HIST_W : 1,
    localparam int ROWS   = 1 << IDX_W,
    localparam int COLS   = 1 << HIST_W,
    localparam int CELLS  = ROWS * COLS,
    localparam int CELL_W = IDX_W + HIST_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic [1:0]      lk_ctr,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken
);
    logic [GW-1:0]      hist_q;
    logic [IDX_W-1:0]   lk_row;
    logic [IDX_W-1:0]   res_row;
    logic [CELL_W-1:0]  lk_cell;
    logic [CELL_W-1:0]  res_cell;
    logic [CELLS*2-1:0] tbl_flat;

    assign lk_row  = lk_pc[PC_LSB +: IDX_W];
    assign res_row = res_pc[PC_LSB +: IDX_W];

    generate
        if (HIST_W > 0) begin : g_sel_hist
            assign lk_cell  = {lk_row, hist_q};
            assign res_cell = {res_row, hist_q};
        end else begin : g_sel_row
            assign lk_cell  = lk_row;
            assign res_cell = res_row;
        end
    endgenerate

    bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .outcome  (res_taken),
        .hist     (hist_q)
    );

    bp_ctr_table #(.CELLS(CELLS), .CELL_W(CELL_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (res_valid),
        .wr_cell  (res_cell),
        .wr_taken (res_taken),
        .tbl_flat (tbl_flat)
    );

    assign lk_ctr   = tbl_flat[lk_cell*2 +: 2];
    assign lk_taken = lk_ctr[1];
endmodule

// File: rtl/corr_predictor_chk.sv
module corr_predictor_chk #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 3,
    parameter int HIST_W = 2,
    localparam int GW     = (HIST_W > 0) ? HIST_W : 1,
    localparam int CELLS  = (1 << IDX_W) * (1 << HIST_W),
    localparam int CELL_W = IDX_W + HIST_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               res_valid,
    input logic [PC_W-1:0]    res_pc,
    input logic               res_taken,
    input logic [GW-1:0]      ghr,
    input logic [CELLS*2-1:0] tbl_flat
);
    logic [CELL_W-1:0] sel;
    logic [1:0]        sel_val;

    generate
        if (HIST_W > 0) begin : g_c
            assign sel = {res_pc[PC_LSB +: IDX_W], ghr};
        end else begin : g_r
            assign sel = res_pc[PC_LSB +: IDX_W];
        end
    endgenerate

    assign sel_val = tbl_flat[sel*2 +: 2];

    generate
        if (HIST_W > 0) begin : g_hist_props
            p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid |=> ghr == GW'({$past(ghr), $past(res_taken)}));
            p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !res_valid |=> $stable(ghr));
        end
    endgenerate

    p_tbl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(tbl_flat));

    p_taken_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && sel_val != 2'b00)
        |=> tbl_flat[$past(sel)*2 +: 2] == 2'b11);

    p_taken_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && sel_val == 2'b00)
        |=> tbl_flat[$past(sel)*2 +: 2] == 2'b01);

    p_nt_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken && sel_val != 2'b11)
        |=> tbl_flat[$past(sel)*2 +: 2] == 2'b00);

    p_nt_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken && sel_val == 2'b11)
        |=> tbl_flat[$past(sel)*2 +: 2] == 2'b10);

    p_one_cell_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> $countones(tbl_flat ^ $past(tbl_flat)) <= 2);
endmodule

bind corr_predictor corr_predictor_chk #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_pc    (res_pc),
    .res_taken (res_taken),
    .ghr       (hist_q),
    .tbl_flat  (tbl_flat)
);

// File: tb/sim_corr_predictor.sv
`timescale 1ns/1ps
module sim_corr_predictor;
    localparam int PC_W   = 32;
    localparam int PC_LSB = 2;
    localparam int IDX_W  = 3;
    localparam int HIST_W = 2;
    localparam int ROWS   = 1 << IDX_W;
    localparam int COLS   = 1 << HIST_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic [1:0]      lk_ctr;
    logic            res_valid = 1'b0;
    logic [PC_W-1:0] res_pc = '0;
    logic            res_taken = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    int mctr [ROWS][COLS];
    int mhist = 0;

    always #2.5 clk = ~clk;

    corr_predictor #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_ctr(lk_ctr),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken)
    );

    function automatic int row_of(input logic [PC_W-1:0] pc);
        return int'((pc >> PC_LSB) & (ROWS - 1));
    endfunction

    function automatic int next_ctr(input int c, input bit t);
        if (t) return (c == 0) ? 1 : 3;
        return (c == 3) ? 2 : 0;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s got %0d expected %0d (time %0t)", tag, got, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, check combinational lookup, model the edge
    task automatic cyc(input logic [PC_W-1:0] lpc, input bit rv,
                       input logic [PC_W-1:0] rpc, input bit rt, input string tag);
        int e;
        int r;
        @(negedge clk);
        lk_pc = lpc; res_valid = rv; res_pc = rpc; res_taken = rt;
        #1;
        e = mctr[row_of(lpc)][mhist];
        check(tag, int'(lk_ctr), e);
        check("R4 direction", int'(lk_taken), (e >= 2) ? 1 : 0);
        if (rv) begin
            r = row_of(rpc);
            mctr[r][mhist] = next_ctr(mctr[r][mhist], rt);
            mhist = ((mhist << 1) | int'(rt)) & (COLS - 1);
        end
    endtask

    task automatic scan(input string tag);
        for (int r = 0; r < ROWS; r++) begin
            cyc(PC_W'(r << PC_LSB) | 32'hA5A0_0000, 1'b0, $urandom, $urandom, tag);
        end
    endtask

    initial begin
        void'($urandom(32'd2015));
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) mctr[r][c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all rows predict not-taken after reset
        scan("R1 reset state");

        // R9/R6/R7: loop branch on row 4 repeatedly taken, then exits
        for (int i = 0; i < 6; i++) cyc(32'h10, 1'b1, 32'h10, 1'b1, "R9 R6 R7 loop body");
        cyc(32'h10, 1'b1, 32'h10, 1'b0, "R8 loop exit");
        cyc(32'h10, 1'b1, 32'h10, 1'b0, "R8 second exit");
        // R2: aliasing addresses share the row
        cyc(32'hFFFF_0010, 1'b0, 32'h0, 1'b0, "R2 alias high bits");
        cyc(32'h0000_0013, 1'b0, 32'h0, 1'b0, "R2 alias low bits");
        // R11: same-cycle lookup sees pre-update state
        cyc(32'h10, 1'b1, 32'h10, 1'b1, "R11 same cycle");
        cyc(32'h10, 1'b0, 32'h10, 1'b1, "R11 next cycle");
        // R10: noisy inputs with valid low change nothing
        for (int i = 0; i < 5; i++) cyc($urandom, 1'b0, $urandom, $urandom, "R10 idle");
        scan("R5 R10 table scan");

        // R3/R5/R7/R8/R9/R11: random mix, biased to few rows
        for (int i = 0; i < 4000; i++) begin
            logic [PC_W-1:0] a;
            a = $urandom;
            cyc(($urandom % 4 == 0) ? a : $urandom, ($urandom % 5) != 0,
                a, ($urandom % 3) != 0, "R3 R7 R8 R9 R11 random");
        end
        scan("R5 final scan");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule